// File: doc/BRIEF.md
# Virtual Timer Compare Access Router

This block decides what happens to a system-register access aimed at the virtual timer compare value. It looks at the requesting privilege level, which of the two instruction encodings was used (the primary one or the alias reachable only from the hypervisor side), and a set of hypervisor, nested-virtualisation and security control bits. From these it selects exactly one outcome. The access may touch the guest compare register. It may be steered to the secure or the non-secure hypervisor virtual compare register, or sent to a memory-backed slot. It may also trap to level 1 or 2, or be rejected as undefined. Performing the access and taking the exception are left to the surrounding pipeline.

The two encodings share op0=0b11, CRn=0b1110, CRm=0b0011 and op2=0b010. The primary encoding has op1=0b011 and the alias has op1=0b101. The decision is made by combinational logic. The result is registered once and paired with a response-valid strobe. Reads and writes follow the same decision tree, and the direction flag is passed through alongside the result.

Top module: `vtcmp_router`

## Requirements
- R1: While `rsp_valid` is 1, exactly one bit of `outcome` is 1. While it is 0, `outcome` is all zero. Bit meanings: 0 guest register, 1 secure hypervisor register, 2 non-secure hypervisor register, 3 memory slot, 4 trap, 5 undefined.
- R2: On a trap outcome, `trap_class` is 0x18 and `trap_level` is 1 or 2. On any other outcome, both are zero.
- R3: At level 0 with the primary encoding, the access traps when the kernel level-0 enable is 0 and the pair (hyp_en AND host_mode AND tge_route) is false. The target is level 2 if hyp_en and tge_route are both 1, and level 1 otherwise.
- R4: At level 0 with the primary encoding and R3 not applying, the access traps to level 2 in either of two cases. The first is that the host pair is true and the hypervisor level-0 enable is 0. The second is that hyp_en is 1, the host pair is false, and the level-1 timer trap bit is 1.
- R5: At level 0 with the primary encoding, once R3 and R4 do not apply and the host pair is true, the access is redirected. It goes to the secure hypervisor register when nonsecure=0 and sec_hyp_present=1, and to the non-secure one when nonsecure=1. Every other case goes to the guest register.
- R6: At level 1 with the primary encoding, the access traps to level 2 when hyp_en and the level-1 trap bit are both 1. Otherwise, with hyp_en=1 and nest_ctl=3'b111, it goes to the memory slot. Otherwise it goes to the guest register.
- R7: At level 2 with the primary encoding and host_mode=1, the access is redirected by the same nonsecure and sec_hyp_present rule as R5. With host_mode=0, or with no redirect selected, it goes to the guest register. At level 3 the primary encoding always reaches the guest register.
- R8: The alias encoding is undefined at level 0. At level 1 with hyp_en=1 and nest_ctl=3'b101, it traps to level 2 if the host pair is false and the nested-counter trap bit is 1, and otherwise goes to the memory slot. If that case does not hold, hyp_en=1 with nest_ctl[0]=1 traps to level 2. Anything else is undefined.
- R9: The alias at level 2 reaches the guest register when host_mode=1 and is undefined otherwise. At level 3 it reaches the guest register only when hyp_en, lvl2_wide and host_mode are all 1, and is undefined otherwise.
- R10: A request sampled with `req_valid`=1 at one rising edge yields `rsp_valid`=1 and its outcome after that same edge. `rsp_write` echoes `req_write`, and the direction never changes the outcome.
- R11: `mem_offset` is 0x168 with the memory-slot outcome and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_alias | input | 1 | 1 selects the alias encoding |
| req_level | input | 2 | Current privilege level, 0 to 3 |
| hyp_en | input | 1 | Hypervisor level enabled |
| host_mode | input | 1 | Hypervisor runs as host |
| tge_route | input | 1 | Route level-0 exceptions to the hypervisor |
| kern_l0_en | input | 1 | Kernel grants level 0 virtual timer access |
| hyp_l0_en | input | 1 | Hypervisor grants level 0 virtual timer access |
| hyp_l1_trap | input | 1 | Hypervisor traps lower-level virtual timer access |
| hyp_nest_trap | input | 1 | Hypervisor traps nested virtual counter alias access |
| nest_ctl | input | 3 | Nested virtualisation controls, bit 2 down to bit 0 |
| nonsecure | input | 1 | Current security state is non-secure |
| sec_hyp_present | input | 1 | Secure hypervisor support implemented |
| lvl2_wide | input | 1 | Level 2 runs in 64-bit state |
| rsp_valid | output | 1 | Decision valid |
| rsp_write | output | 1 | Echo of the request direction |
| outcome | output | 6 | One-hot outcome |
| trap_level | output | 2 | Target level of a trap |
| trap_class | output | 8 | Syndrome class of a trap |
| mem_offset | output | 12 | Memory slot offset |

## Verification
A wrong branch in the priority tree shows up as the wrong one-hot bit on `outcome`. A missing or mis-set target shows up on `trap_level`. Either error is visible in the first cycle after the request edge, because there is only one register stage. An output register that fails to clear or update makes `outcome` have zero or two bits set, or breaks the one-cycle pairing with `rsp_valid`. Those faults are also visible at the next edge.

// File: rtl/vtcmp_route_pkg.sv
package vtcmp_route_pkg;
  localparam int OUT_N   = 6;
  localparam int O_GUEST = 0;
  localparam int O_HSEC  = 1;
  localparam int O_HNS   = 2;
  localparam int O_MEM   = 3;
  localparam int O_TRAP  = 4;
  localparam int O_UNDEF = 5;

  typedef struct packed {
    logic       hyp_en;
    logic       host_mode;
    logic       tge_route;
    logic       kern_l0_en;
    logic       hyp_l0_en;
    logic       hyp_l1_trap;
    logic       hyp_nest_trap;
    logic [2:0] nest_ctl;
    logic       nonsecure;
    logic       sec_hyp_present;
    logic       lvl2_wide;
  } ctl_t;

  typedef struct packed {
    logic [OUT_N-1:0] hot;
    logic [1:0]       lvl;
  } verdict_t;

  function automatic verdict_t pick(input int idx, input logic [1:0] tl);
    verdict_t v;
    v.hot = '0;
    v.hot[idx] = 1'b1;
    v.lvl = tl;
    return v;
  endfunction
endpackage

// File: rtl/vtcmp_primary_dec.sv
module vtcmp_primary_dec
  import vtcmp_route_pkg::*;
(
  input  logic [1:0] level,
  input  ctl_t       c,
  output verdict_t   v
);
  logic pair_host;
  logic pair_other;
  verdict_t redir;

  assign pair_host  = c.hyp_en & c.host_mode & c.tge_route;
  assign pair_other = c.hyp_en & ~(c.host_mode & c.tge_route);

  always_comb begin
    if (c.host_mode && !c.nonsecure && c.sec_hyp_present) redir = pick(O_HSEC, 2'd0);
    else if (c.host_mode && c.nonsecure)                   redir = pick(O_HNS, 2'd0);
    else                                                    redir = pick(O_GUEST, 2'd0);
  end

  always_comb begin
    v = pick(O_GUEST, 2'd0);
    unique case (level)
      2'd0: begin
        if (!pair_host && !c.kern_l0_en)
          v = pick(O_TRAP, (c.hyp_en && c.tge_route) ? 2'd2 : 2'd1);
        else if (pair_host && !c.hyp_l0_en)
          v = pick(O_TRAP, 2'd2);
        else if (pair_other && c.hyp_l1_trap)
          v = pick(O_TRAP, 2'd2);
        else if (pair_host)
          v = redir;
        else
          v = pick(O_GUEST, 2'd0);
      end
      2'd1: begin
        if (c.hyp_en && c.hyp_l1_trap)
          v = pick(O_TRAP, 2'd2);
        else if (c.hyp_en && c.nest_ctl == 3'b111)
          v = pick(O_MEM, 2'd0);
        else
          v = pick(O_GUEST, 2'd0);
      end
      2'd2: v = redir;
      default: v = pick(O_GUEST, 2'd0);
    endcase
  end
endmodule

// File: rtl/vtcmp_alias_dec.sv
module vtcmp_alias_dec
  import vtcmp_route_pkg::*;
(
  input  logic [1:0] level,
  input  ctl_t       c,
  output verdict_t   v
);
  logic pair_other;
  assign pair_other = c.hyp_en & ~(c.host_mode & c.tge_route);

  always_comb begin
    v = pick(O_UNDEF, 2'd0);
    unique case (level)
      2'd0: v = pick(O_UNDEF, 2'd0);
      2'd1: begin
        if (c.hyp_en && c.nest_ctl == 3'b101) begin
          if (pair_other && c.hyp_nest_trap) v = pick(O_TRAP, 2'd2);
          else                               v = pick(O_MEM, 2'd0);
        end else if (c.hyp_en && c.nest_ctl[0]) begin
          v = pick(O_TRAP, 2'd2);
        end else begin
          v = pick(O_UNDEF, 2'd0);
        end
      end
      2'd2: v = c.host_mode ? pick(O_GUEST, 2'd0) : pick(O_UNDEF, 2'd0);
      default: v = (c.hyp_en && c.lvl2_wide && c.host_mode) ?
                   pick(O_GUEST, 2'd0) : pick(O_UNDEF, 2'd0);
    endcase
  end
endmodule

// File: rtl/vtcmp_router.sv
module vtcmp_router
  import vtcmp_route_pkg::*;
#(
  parameter int          CLASS_W   = 8,
  parameter int          OFF_W     = 12,
  parameter logic [7:0]  TRAP_EC   = 8'h18,
  parameter logic [11:0] SLOT_OFF  = 12'h168,
  parameter bit          REG_OUT   = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_alias,
  input  logic [1:0]         req_level,
  input  logic               hyp_en,
  input  logic               host_mode,
  input  logic               tge_route,
  input  logic               kern_l0_en,
  input  logic               hyp_l0_en,
  input  logic               hyp_l1_trap,
  input  logic               hyp_nest_trap,
  input  logic [2:0]         nest_ctl,
  input  logic               nonsecure,
  input  logic               sec_hyp_present,
  input  logic               lvl2_wide,
  output logic               rsp_valid,
  output logic               rsp_write,
  output logic [OUT_N-1:0]   outcome,
  output logic [1:0]         trap_level,
  output logic [CLASS_W-1:0] trap_class,
  output logic [OFF_W-1:0]   mem_offset
);
  localparam logic [CLASS_W-1:0] EC_W  = CLASS_W'(TRAP_EC);
  localparam logic [OFF_W-1:0]   OFF_V = OFF_W'(SLOT_OFF);

  ctl_t     ctl;
  verdict_t v_pri, v_ali, v_sel;
  logic [OUT_N-1:0]   hot_n;
  logic [1:0]         lvl_n;
  logic [CLASS_W-1:0] cls_n;
  logic [OFF_W-1:0]   off_n;

  assign ctl = '{hyp_en: hyp_en, host_mode: host_mode, tge_route: tge_route,
                 kern_l0_en: kern_l0_en, hyp_l0_en: hyp_l0_en,
                 hyp_l1_trap: hyp_l1_trap, hyp_nest_trap: hyp_nest_trap,
                 nest_ctl: nest_ctl, nonsecure: nonsecure,
                 sec_hyp_present: sec_hyp_present, lvl2_wide: lvl2_wide};

  vtcmp_primary_dec u_pri (.level(req_level), .c(ctl), .v(v_pri));
  vtcmp_alias_dec   u_ali (.level(req_level), .c(ctl), .v(v_ali));

  assign v_sel = req_alias ? v_ali : v_pri;

  always_comb begin
    hot_n = req_valid ? v_sel.hot : '0;
    lvl_n = (req_valid && v_sel.hot[O_TRAP]) ? v_sel.lvl : 2'd0;
    cls_n = (req_valid && v_sel.hot[O_TRAP]) ? EC_W : '0;
    off_n = (req_valid && v_sel.hot[O_MEM])  ? OFF_V : '0;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          rsp_valid  <= 1'b0;
          rsp_write  <= 1'b0;
          outcome    <= '0;
          trap_level <= '0;
          trap_class <= '0;
          mem_offset <= '0;
        end else begin
          rsp_valid  <= req_valid;
          rsp_write  <= req_valid & req_write;
          outcome    <= hot_n;
          trap_level <= lvl_n;
          trap_class <= cls_n;
          mem_offset <= off_n;
        end
      end
    end else begin : g_comb
      always_comb begin
        rsp_valid  = req_valid;
        rsp_write  = req_valid & req_write;
        outcome    = hot_n;
        trap_level = lvl_n;
        trap_class = cls_n;
        mem_offset = off_n;
      end
    end
  endgenerate
endmodule

// File: rtl/vtcmp_router_chk.sv
module vtcmp_router_chk
  import vtcmp_route_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_alias,
  input logic [1:0]       req_level,
  input logic             rsp_valid,
  input logic [OUT_N-1:0] outcome,
  input logic [1:0]       trap_level,
  input logic [7:0]       trap_class,
  input logic [11:0]      mem_offset
);
  // R1
  onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(outcome) == 1);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> outcome == '0);
  // R2
  trap_fields_chk: assert property (@(posedge clk) disable iff (rst)
    outcome[O_TRAP] |-> (trap_class == 8'h18 && (trap_level == 2'd1 || trap_level == 2'd2)));
  // R2
  notrap_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !outcome[O_TRAP] |-> (trap_class == 8'h00 && trap_level == 2'd0));
  // R8
  alias_l0_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_alias && req_level == 2'd0) |=> outcome[O_UNDEF]);
  // R7
  l3_primary_guest_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_alias && req_level == 2'd3) |=> outcome[O_GUEST]);
  // R10
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R11
  mem_off_chk: assert property (@(posedge clk) disable iff (rst)
    outcome[O_MEM] |-> mem_offset == 12'h168);
endmodule

bind vtcmp_router vtcmp_router_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_alias(req_alias),
  .req_level(req_level), .rsp_valid(rsp_valid), .outcome(outcome),
  .trap_level(trap_level), .trap_class(trap_class), .mem_offset(mem_offset)
);

// File: tb/vtcmp_router_tb.sv
module vtcmp_router_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_alias = 0;
  logic [1:0] req_level = 0;
  logic hyp_en = 0, host_mode = 0, tge_route = 0, kern_l0_en = 0, hyp_l0_en = 0;
  logic hyp_l1_trap = 0, hyp_nest_trap = 0, nonsecure = 0, sec_hyp_present = 0, lvl2_wide = 0;
  logic [2:0] nest_ctl = 0;
  logic rsp_valid, rsp_write;
  logic [5:0] outcome;
  logic [1:0] trap_level;
  logic [7:0] trap_class;
  logic [11:0] mem_offset;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vtcmp_router u_dut (.*);

  // expected model: returns outcome bit index, sets trap level and tag
  function automatic int model(output int tl, output string tag);
    bit ph, po;
    ph = hyp_en && host_mode && tge_route;
    po = hyp_en && !(host_mode && tge_route);
    tl = 0;
    if (!req_alias) begin
      case (req_level)
        2'd0: begin
          if (!ph && !kern_l0_en) begin tag = "R3"; tl = (hyp_en && tge_route) ? 2 : 1; return 4; end
          if (ph && !hyp_l0_en) begin tag = "R4"; tl = 2; return 4; end
          if (po && hyp_l1_trap) begin tag = "R4"; tl = 2; return 4; end
          tag = "R5";
          if (ph && !nonsecure && sec_hyp_present) return 1;
          if (ph && nonsecure) return 2;
          return 0;
        end
        2'd1: begin
          tag = "R6";
          if (hyp_en && hyp_l1_trap) begin tl = 2; return 4; end
          if (hyp_en && nest_ctl == 3'b111) return 3;
          return 0;
        end
        2'd2: begin
          tag = "R7";
          if (host_mode && !nonsecure && sec_hyp_present) return 1;
          if (host_mode && nonsecure) return 2;
          return 0;
        end
        default: begin tag = "R7"; return 0; end
      endcase
    end else begin
      case (req_level)
        2'd0: begin tag = "R8"; return 5; end
        2'd1: begin
          tag = "R8";
          if (hyp_en && nest_ctl == 3'b101) begin
            if (po && hyp_nest_trap) begin tl = 2; return 4; end
            return 3;
          end
          if (hyp_en && nest_ctl[0]) begin tl = 2; return 4; end
          return 5;
        end
        2'd2: begin tag = "R9"; return host_mode ? 0 : 5; end
        default: begin tag = "R9"; return (hyp_en && lvl2_wide && host_mode) ? 0 : 5; end
      endcase
    end
  endfunction

  task automatic fail(input string tag, input string what, input longint act, input longint exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // called at a negedge with inputs set; checks after the next rising edge
  task automatic run_one();
    int idx, tl;
    string tag;
    logic [5:0] eh;
    logic w;
    idx = model(tl, tag);
    eh = 6'b1 << idx;
    w = req_write;
    req_valid = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    checks++;
    if (outcome !== eh || rsp_valid !== 1'b1) fail(tag, "outcome", outcome, eh);
    checks++;
    if (trap_level !== 2'(tl) || trap_class !== ((idx == 4) ? 8'h18 : 8'h00))
      fail("R2", "trap_level/class", {trap_level, trap_class}, {2'(tl), ((idx == 4) ? 8'h18 : 8'h00)});
    if (idx == 3 || mem_offset !== 12'h0) begin
      checks++;
      if (mem_offset !== ((idx == 3) ? 12'h168 : 12'h0)) fail("R11", "mem_offset", mem_offset, (idx == 3) ? 12'h168 : 12'h0);
    end
    if (rsp_write !== w) begin checks++; fail("R10", "rsp_write", rsp_write, w); end
  endtask

  task automatic clear_ctl();
    {hyp_en, host_mode, tge_route, kern_l0_en, hyp_l0_en, hyp_l1_trap, hyp_nest_trap} = '0;
    {nonsecure, sec_hyp_present, lvl2_wide} = '0;
    nest_ctl = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    checks++;
    if (rsp_valid !== 1'b0 || outcome !== 6'h0) fail("R1", "reset outcome", outcome, 0);
    // R3 level 0 trap to level 1 with no hypervisor
    clear_ctl(); req_level = 0; req_alias = 0; run_one();
    // R3 trap to level 2 with tge set but not host pair
    clear_ctl(); hyp_en = 1; tge_route = 1; run_one();
    // R4 host pair, hypervisor level-0 enable clear
    clear_ctl(); hyp_en = 1; host_mode = 1; tge_route = 1; run_one();
    // R5 secure and non-secure redirection
    hyp_l0_en = 1; sec_hyp_present = 1; run_one();
    nonsecure = 1; run_one();
    nonsecure = 0; sec_hyp_present = 0; run_one();
    // R6 memory slot at level 1
    clear_ctl(); req_level = 1; hyp_en = 1; nest_ctl = 3'b111; run_one();
    // R7 level 3 always guest, write direction echoed (R10)
    clear_ctl(); req_level = 3; hyp_l1_trap = 1; hyp_en = 1; req_write = 1; run_one();
    req_write = 0;
    // R8 alias at level 0 and memory / trap at level 1
    clear_ctl(); req_alias = 1; req_level = 0; hyp_en = 1; host_mode = 1; run_one();
    req_level = 1; nest_ctl = 3'b101; run_one();
    hyp_nest_trap = 1; run_one();
    nest_ctl = 3'b001; run_one();
    // R9 alias at levels 2 and 3
    clear_ctl(); req_alias = 1; req_level = 2; run_one();
    host_mode = 1; run_one();
    req_level = 3; run_one();
    hyp_en = 1; lvl2_wide = 1; run_one();
    // R10 direction does not change outcome: random stimulus with both directions
    for (int i = 0; i < 1500; i++) begin
      {hyp_en, host_mode, tge_route, kern_l0_en, hyp_l0_en, hyp_l1_trap, hyp_nest_trap} = 7'($urandom);
      {nonsecure, sec_hyp_present, lvl2_wide} = 3'($urandom);
      nest_ctl = 3'($urandom);
      req_level = 2'($urandom);
      req_alias = 1'($urandom);
      req_write = 1'($urandom);
      run_one();
      if ((i % 7) == 0) begin
        @(posedge clk); @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || outcome !== 6'h0) fail("R1", "idle outcome", outcome, 0);
      end
    end
    finish_up();
  end
endmodule